// File: doc/BRIEF.md
# Sensor SPI Register Access Engine

This block performs single-byte register reads and writes on a motion sensor attached over SPI. A client presents a command on a ready/valid port. The command holds a 7-bit register address, a direction flag and, for writes, one data byte. The engine then runs one chip-select-framed, two-byte SPI transaction in mode 3. A read returns the byte shifted in from the sensor on a one-cycle strobe.

The direction travels in the most significant bit of the first byte on the wire. That bit is 1 for a write and 0 for a read, and the lower seven bits carry the address. The sensor needs time to recover after each access, and a write needs more time than a read. For that reason the engine keeps chip select released for a recovery gap whose length depends on the direction of the access just finished. Only after that gap does it accept the next command.

The SCLK half period and both gap lengths are parameters in system-clock cycles. Their defaults come from the system clock frequency, giving a 2 MHz serial clock, 120 µs of recovery after a write and 20 µs after a read.

Top module: `spi_reg_engine`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_sclk` is 1, `cmd_ready` is 1 and `rd_valid` is 0.
- R2: SCLK idles high whenever chip select is released. During a transaction it toggles with a half period of exactly HALF_DIV system cycles, with 2·HALF_DIV cycles between successive rising edges.
- R3: Bits travel most significant bit first. MOSI changes only on a falling SCLK edge, and both sides sample on the rising edge.
- R4: A write sends the byte {1, addr[6:0]} followed by the data byte, inside one chip-select assertion.
- R5: A read sends the byte {0, addr[6:0]} and then captures the 8 bits that the sensor drives during the second byte, first bit as bit 7. The byte appears on `rd_data` together with a `rd_valid` pulse exactly one cycle long.
- R6: `cmd_ready` is low from the accepting edge until the recovery gap has ended. `cmd_valid` asserted while `cmd_ready` is low is ignored and starts no transaction.
- R7: After a write, chip select stays high for at least WR_GAP_CYC cycles. If the next command is already waiting, chip select falls exactly WR_GAP_CYC+3 cycles after it rose.
- R8: After a read, chip select stays high for at least RD_GAP_CYC cycles. If the next command is already waiting, chip select falls exactly RD_GAP_CYC+3 cycles after it rose.
- R9: A write never produces a `rd_valid` pulse.
- R10: Each accepted command produces exactly one chip-select assertion containing exactly 16 rising SCLK edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine can accept a command |
| cmd_write | input | 1 | 1 = register write, 0 = register read |
| cmd_addr | input | 7 | Register address |
| cmd_wdata | input | 8 | Data byte for a write |
| rd_valid | output | 1 | One-cycle strobe: read data available |
| rd_data | output | 8 | Byte returned by the last read |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idle high |
| spi_mosi | output | 1 | Serial data to the sensor |
| spi_miso | input | 1 | Serial data from the sensor |

## Verification
Two events land in the same cycle, the cycle just after chip select rises at the end of a read: the read-data strobe fires and the recovery timer is loaded. A read is therefore followed at once by another command that is already waiting on the port. The bench then checks two things independently: the returned byte arrives on its strobe, and the next chip-select fall comes exactly RD_GAP_CYC+3 cycles after the release. The second coincidence is a command held on the port while the engine is busy. The bench keeps `cmd_valid` high with unrelated contents during a transfer, then checks that `cmd_ready` stays low and that no extra frame appears on the wire.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_XFER,
        ENG_GAP
    } eng_state_e;

    typedef enum logic [2:0] {
        SH_IDLE,
        SH_LEAD,
        SH_LOW,
        SH_HIGH,
        SH_TRAIL
    } sh_phase_e;

    // Two-byte frame: direction flag in bit 15, address below it, then payload.
    function automatic logic [15:0] frame_word(input logic wr,
                                               input logic [6:0] addr,
                                               input logic [7:0] wdata);
        return {wr, addr, (wr ? wdata : 8'h00)};
    endfunction

endpackage

// File: rtl/spi_reg_shifter.sv
module spi_reg_shifter
    import spi_reg_pkg::*;
#(
    parameter int HALF_DIV   = 50,
    parameter int FRAME_BITS = 16,
    parameter int RX_BITS    = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [FRAME_BITS-1:0] tx_word_i,
    input  logic                  miso_i,
    output logic                  cs_n_o,
    output logic                  sclk_o,
    output logic                  mosi_o,
    output logic [RX_BITS-1:0]    rx_byte_o,
    output logic                  done_o
);

    localparam int HC_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int BC_W = $clog2(FRAME_BITS);
    localparam logic [HC_W-1:0] HC_LAST = HC_W'(HALF_DIV - 1);
    localparam logic [BC_W-1:0] BC_LAST = BC_W'(FRAME_BITS - 1);

    typedef struct packed {
        sh_phase_e             phase;
        logic [HC_W-1:0]       half_cnt;
        logic [BC_W-1:0]       bit_cnt;
        logic [FRAME_BITS-1:0] shreg;
        logic [RX_BITS-1:0]    rxreg;
        logic                  cs_n;
        logic                  sclk;
        logic                  mosi;
        logic                  done;
    } sh_state_t;

    sh_state_t q, d;
    logic half_end;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        half_end = (q.half_cnt == HC_LAST);
        if (q.phase != SH_IDLE) begin
            d.half_cnt = half_end ? '0 : HC_W'(q.half_cnt + 1'b1);
        end
        case (q.phase)
            SH_IDLE: begin
                if (start_i) begin
                    d.phase    = SH_LEAD;
                    d.cs_n     = 1'b0;
                    d.shreg    = tx_word_i;
                    d.bit_cnt  = '0;
                    d.half_cnt = '0;
                end
            end
            SH_LEAD: begin
                if (half_end) begin
                    d.phase = SH_LOW;
                    d.sclk  = 1'b0;
                    d.mosi  = q.shreg[FRAME_BITS-1];
                end
            end
            SH_LOW: begin
                if (half_end) begin
                    d.phase = SH_HIGH;
                    d.sclk  = 1'b1;
                    d.rxreg = {q.rxreg[RX_BITS-2:0], miso_i};
                end
            end
            SH_HIGH: begin
                if (half_end) begin
                    if (q.bit_cnt == BC_LAST) begin
                        d.phase = SH_TRAIL;
                    end else begin
                        d.phase   = SH_LOW;
                        d.bit_cnt = BC_W'(q.bit_cnt + 1'b1);
                        d.shreg   = {q.shreg[FRAME_BITS-2:0], 1'b0};
                        d.sclk    = 1'b0;
                        d.mosi    = q.shreg[FRAME_BITS-2];
                    end
                end
            end
            SH_TRAIL: begin
                if (half_end) begin
                    d.phase = SH_IDLE;
                    d.cs_n  = 1'b1;
                    d.done  = 1'b1;
                end
            end
            default: d.phase = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.phase    <= SH_IDLE;
            q.cs_n     <= 1'b1;
            q.sclk     <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign cs_n_o    = q.cs_n;
    assign sclk_o    = q.sclk;
    assign mosi_o    = q.mosi;
    assign rx_byte_o = q.rxreg;
    assign done_o    = q.done;

    // MOSI may only move together with a falling SCLK edge.
    assert_mosi_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.mosi) |-> $fell(q.sclk));

    // Chip select is never released while SCLK is low.
    assert_release_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.cs_n) |-> q.sclk);

endmodule

// File: rtl/spi_reg_gap_timer.sv
module spi_reg_gap_timer #(
    parameter int WR_GAP_CYC = 24000,
    parameter int RD_GAP_CYC = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic wr_i,
    output logic busy_o
);

    localparam int GAP_MAX = (WR_GAP_CYC > RD_GAP_CYC) ? WR_GAP_CYC : RD_GAP_CYC;
    localparam int CNT_W   = $clog2(GAP_MAX + 1);
    localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_GAP_CYC - 1);
    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_GAP_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             busy;
    } gap_state_t;

    gap_state_t q, d;

    always_comb begin
        d = q;
        if (load_i) begin
            d.busy = 1'b1;
            d.cnt  = wr_i ? WR_LOAD : RD_LOAD;
        end else if (q.busy) begin
            if (q.cnt == '0) begin
                d.busy = 1'b0;
            end else begin
                d.cnt = CNT_W'(q.cnt - 1'b1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o = q.busy;

    // A load always opens a recovery window on the next cycle.
    assert_load_opens_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> busy_o);

    // The counter never exceeds the longer of the two windows.
    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> (q.cnt < CNT_W'(GAP_MAX)));

endmodule

// File: rtl/spi_reg_engine.sv
module spi_reg_engine
    import spi_reg_pkg::*;
#(
    parameter int CLK_HZ     = 200_000_000,
    parameter int SCLK_HZ    = 2_000_000,
    parameter int HALF_DIV   = CLK_HZ / (2 * SCLK_HZ),
    parameter int WR_GAP_CYC = (CLK_HZ / 1_000_000) * 120,
    parameter int RD_GAP_CYC = (CLK_HZ / 1_000_000) * 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    output logic       cmd_ready,
    input  logic       cmd_write,
    input  logic [6:0] cmd_addr,
    input  logic [7:0] cmd_wdata,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    output logic       spi_cs_n,
    output logic       spi_sclk,
    output logic       spi_mosi,
    input  logic       spi_miso
);

    localparam int FRAME_BITS = 16;
    localparam int RX_BITS    = 8;
    localparam int GAP_MAX    = (WR_GAP_CYC > RD_GAP_CYC) ? WR_GAP_CYC : RD_GAP_CYC;
    localparam int HI_W       = $clog2(GAP_MAX + 1);

    typedef struct packed {
        eng_state_e         state;
        logic               wr;
        logic               rd_valid;
        logic [RX_BITS-1:0] rd_data;
    } eng_t;

    eng_t q, d;

    logic               sh_start;
    logic               sh_done;
    logic [RX_BITS-1:0] sh_rx;
    logic               gap_load;
    logic               gap_busy;

    spi_reg_shifter #(
        .HALF_DIV   (HALF_DIV),
        .FRAME_BITS (FRAME_BITS),
        .RX_BITS    (RX_BITS)
    ) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (sh_start),
        .tx_word_i (frame_word(cmd_write, cmd_addr, cmd_wdata)),
        .miso_i    (spi_miso),
        .cs_n_o    (spi_cs_n),
        .sclk_o    (spi_sclk),
        .mosi_o    (spi_mosi),
        .rx_byte_o (sh_rx),
        .done_o    (sh_done)
    );

    spi_reg_gap_timer #(
        .WR_GAP_CYC (WR_GAP_CYC),
        .RD_GAP_CYC (RD_GAP_CYC)
    ) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (gap_load),
        .wr_i   (q.wr),
        .busy_o (gap_busy)
    );

    always_comb begin
        d          = q;
        d.rd_valid = 1'b0;
        sh_start   = 1'b0;
        gap_load   = 1'b0;
        case (q.state)
            ENG_IDLE: begin
                if (cmd_valid) begin
                    sh_start = 1'b1;
                    d.wr     = cmd_write;
                    d.state  = ENG_XFER;
                end
            end
            ENG_XFER: begin
                if (sh_done) begin
                    gap_load = 1'b1;
                    d.state  = ENG_GAP;
                    if (!q.wr) begin
                        d.rd_valid = 1'b1;
                        d.rd_data  = sh_rx;
                    end
                end
            end
            ENG_GAP: begin
                if (!gap_busy) begin
                    d.state = ENG_IDLE;
                end
            end
            default: d.state = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ENG_IDLE;
        end else begin
            q <= d;
        end
    end

    assign cmd_ready = (q.state == ENG_IDLE);
    assign rd_valid  = q.rd_valid;
    assign rd_data   = q.rd_data;

    // Checker support: cycles since chip-select release and the last direction.
    logic [HI_W-1:0] hi_cnt_q;
    logic            last_wr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt_q  <= HI_W'(GAP_MAX);
            last_wr_q <= 1'b0;
        end else begin
            if (!spi_cs_n) begin
                hi_cnt_q <= '0;
            end else if (hi_cnt_q < HI_W'(GAP_MAX)) begin
                hi_cnt_q <= HI_W'(hi_cnt_q + 1'b1);
            end
            if (sh_done) begin
                last_wr_q <= q.wr;
            end
        end
    end

    assert_sclk_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> spi_sclk);

    assert_busy_while_framed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> !cmd_ready);

    assert_rd_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    assert_no_strobe_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !last_wr_q);

    assert_write_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(spi_cs_n) && last_wr_q) |-> (hi_cnt_q >= HI_W'(WR_GAP_CYC)));

    assert_read_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(spi_cs_n) && !last_wr_q) |-> (hi_cnt_q >= HI_W'(RD_GAP_CYC)));

endmodule

// File: tb/spi_reg_engine_bench.sv
module spi_reg_engine_bench;

    localparam int HALF = 3;
    localparam int WRG  = 40;
    localparam int RDG  = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic       cmd_write = 1'b0;
    logic [6:0] cmd_addr = '0;
    logic [7:0] cmd_wdata = '0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       spi_cs_n;
    logic       spi_sclk;
    logic       spi_mosi;
    logic       spi_miso = 1'b0;

    always #2.5 clk = ~clk;

    spi_reg_engine #(
        .HALF_DIV   (HALF),
        .WR_GAP_CYC (WRG),
        .RD_GAP_CYC (RDG)
    ) u_spi_reg_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_write (cmd_write),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .spi_cs_n  (spi_cs_n),
        .spi_sclk  (spi_sclk),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] sensor_resp(input logic [6:0] a);
        return {a, 1'b1} ^ 8'h3C;
    endfunction

    // ---------------- sensor model (mode 3) ----------------
    logic [15:0] mosi_cap = '0;
    int          rise_cnt = 0;
    logic [6:0]  addr_seen = '0;
    int          cyc = 0;
    int          last_rise = 0;
    bit          period_err = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge spi_cs_n) begin
        rise_cnt   = 0;
        mosi_cap   = '0;
        period_err = 1'b0;
    end

    always @(posedge spi_sclk) begin
        if (!spi_cs_n) begin
            if (rise_cnt > 0 && (cyc - last_rise) != 2 * HALF) period_err = 1'b1;
            last_rise = cyc;
            mosi_cap  = {mosi_cap[14:0], spi_mosi};
            rise_cnt++;
            if (rise_cnt == 8) addr_seen = mosi_cap[6:0];
        end
    end

    always @(negedge spi_sclk) begin
        if (!spi_cs_n && rise_cnt >= 8 && rise_cnt < 16)
            spi_miso = sensor_resp(addr_seen)[15 - rise_cnt];
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        bit         wr;
        logic [6:0] a;
        logic [7:0] d;
        bit         waited;
    } item_t;

    item_t      exp_q[$];
    logic [7:0] rd_q[$];
    int         frames = 0;
    int         sent = 0;
    int         reads_sent = 0;
    int         strobes = 0;
    int         hi_run = 0;
    bit         prev_wr = 1'b0;
    bit         prev_cs = 1'b1;
    bit         prev_rv = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            // frame start: recovery gap check
            if (!spi_cs_n && prev_cs && frames > 0 && exp_q.size() > 0) begin
                if (exp_q[0].waited)
                    chk(hi_run == (prev_wr ? WRG : RDG) + 3, prev_wr ? "R7" : "R8",
                        hi_run, (prev_wr ? WRG : RDG) + 3);
                else
                    chk(hi_run >= (prev_wr ? WRG : RDG), prev_wr ? "R7" : "R8",
                        hi_run, prev_wr ? WRG : RDG);
            end
            // frame end: content check
            if (spi_cs_n && !prev_cs) begin
                item_t it;
                frames++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected frame", frames, sent);
                end else begin
                    it = exp_q.pop_front();
                    chk(rise_cnt == 16, "R10 rising edges", rise_cnt, 16);
                    chk(!period_err, "R2 sclk period", period_err, 0);
                    if (it.wr) begin
                        chk(mosi_cap == {1'b1, it.a, it.d}, "R4 write frame", mosi_cap,
                            {1'b1, it.a, it.d});
                    end else begin
                        chk(mosi_cap[15:8] == {1'b0, it.a}, "R5 read address byte",
                            mosi_cap[15:8], {1'b0, it.a});
                        chk(mosi_cap[15:8] == {1'b0, it.a}, "R3 msb first",
                            mosi_cap[15], 1'b0);
                        rd_q.push_back(sensor_resp(it.a));
                    end
                    prev_wr = it.wr;
                end
            end
            if (rd_valid) begin
                strobes++;
                chk(!prev_rv, "R5 strobe width", prev_rv, 0);
                if (rd_q.size() == 0) begin
                    chk(1'b0, "R9 strobe without read", rd_data, 0);
                end else begin
                    logic [7:0] e;
                    e = rd_q.pop_front();
                    chk(rd_data == e, "R5 read data", rd_data, e);
                end
            end
            if (spi_cs_n && !spi_sclk) chk(1'b0, "R2 sclk idle high", spi_sclk, 1);
            hi_run  = spi_cs_n ? ((spi_cs_n && !prev_cs) ? 1 : hi_run + 1) : 0;
            prev_cs = spi_cs_n;
            prev_rv = rd_valid;
        end
    end

    // ---------------- driver ----------------
    task automatic send(input bit wr, input logic [6:0] a, input logic [7:0] dt,
                        input bit poke);
        item_t it;
        it.wr = wr; it.a = a; it.d = dt; it.waited = !cmd_ready;
        exp_q.push_back(it);
        sent++;
        if (!wr) reads_sent++;
        cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = dt;
        forever begin
            if (cmd_ready) begin
                @(posedge clk);
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        if (poke) begin
            for (int i = 0; i < 5; i++) begin
                cmd_valid = 1'b1; cmd_write = ~wr; cmd_addr = ~a; cmd_wdata = ~dt;
                chk(!cmd_ready, "R6 ready low while busy", cmd_ready, 0);
                @(negedge clk);
            end
            cmd_valid = 1'b0;
        end
    endtask

    task automatic run_tests();
        repeat (5) @(negedge clk);
        chk(spi_cs_n == 1'b1, "R1 cs_n", spi_cs_n, 1);
        chk(spi_sclk == 1'b1, "R1 sclk", spi_sclk, 1);
        chk(cmd_ready == 1'b1, "R1 ready", cmd_ready, 1);
        chk(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // write then reads back to back
        send(1'b1, 7'h3A, 8'h5A, 1'b0);
        send(1'b0, 7'h02, 8'h00, 1'b0);
        send(1'b0, 7'h03, 8'h00, 1'b0);
        send(1'b1, 7'h0F, 8'h29, 1'b0);
        send(1'b1, 7'h20, 8'h00, 1'b0);
        send(1'b0, 7'h7F, 8'h00, 1'b0);
        repeat (70) @(negedge clk);
        // boundary values after an idle pause
        send(1'b0, 7'h00, 8'h00, 1'b0);
        send(1'b1, 7'h7F, 8'hFF, 1'b0);
        send(1'b1, 7'h00, 8'h00, 1'b0);
        // commands presented while busy are ignored
        send(1'b0, 7'h55, 8'h00, 1'b1);
        send(1'b1, 7'h2A, 8'hA5, 1'b1);
        repeat (200) @(negedge clk);
        chk(cmd_ready == 1'b1, "R6 ready after gap", cmd_ready, 1);
        chk(frames == sent, "R6 frame count", frames, sent);
        chk(strobes == reads_sent, "R9 strobe count", strobes, reads_sent);
        chk(exp_q.size() == 0 && rd_q.size() == 0, "R10 scoreboard drained",
            exp_q.size() + rd_q.size(), 0);
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (200000) @(posedge clk);
                chk(1'b0, "watchdog", 0, 1);
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule